// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block is a 16-line general-purpose I/O controller with a 32-bit memory-mapped register interface. Software sets each line's output value and direction and reads back the pin states. Every line has its own programmable trigger style: active-high level, active-low level, rising edge, falling edge or either edge. A line that meets its condition latches a bit in a status register, and software clears that bit by writing a one to it.

Pin inputs pass through a two-flop synchronizer. The edge styles compare the synchronized sample with the sample one cycle older. Lines 0 to 12 each drive a dedicated active-high interrupt output that follows the line's status bit. Lines 13 to 15 latch status that can be read, but they drive no interrupt output. The clock-control and debounce-select words are plain storage only.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, output data is 0, every line is an input (pin_oe_o = 0), both style words are 0, status is 0 and irq_o is 0.
- R2: The byte address selects a word: 0x00 output data [15:0], 0x04 direction [15:0], 0x08 input data [15:0] (read-only), 0x0C status [15:0], 0x10 styles for lines 0-7 [23:0], 0x14 styles for lines 8-15 [23:0], 0x18 clock control [31:0], 0x1C debounce select [31:0]. Unused bits read zero. An access with addr_i[1:0] != 0 writes nothing and reads zero. Read data is combinational from addr_i.
- R3: A direction bit of 1 makes the line an input (pin_oe_o bit 0). A direction bit of 0 makes the line drive (pin_oe_o bit 1). pin_o always equals the output data word.
- R4: The input data word returns, for all 16 lines and regardless of direction, the pin values delayed by two clock edges.
- R5: Line n of 0-7 takes its 3-bit style from bits [3n+2:3n] of word 0x10. Line n of 8-15 takes its style from bits [3(n-8)+2:3(n-8)] of word 0x14.
- R6: Style 0 (high level) and style 1 (low level) set the status bit on every cycle the synchronized level matches. A clear written while the level persists has no effect.
- R7: Style 2 (rising edge), style 3 (falling edge) and style 4 (either edge) set the status bit only on the qualifying transition of the synchronized input.
- R8: Styles 5, 6 and 7 never set status.
- R9: A write to 0x0C clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A set condition in the same cycle wins over the clear.
- R10: irq_o[k] equals status bit k for k = 0..12. Status bits 13-15 can be read but drive no output.
- R11: A qualifying pin change made before clock edge 1 shows on status and irq_o after clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Per-line output drive enable |
| irq_o | output | 13 | Interrupt outputs for lines 0 to 12 |

## Verification
The hardest case to reach is a status write that arrives in the same cycle as a set condition. Two such cases are an active level and a fresh edge landing under a clear of random bits. A second hard case is a style change that reinterprets a pin already sitting at a level. Directed steps first hold a low-level line active while it is cleared. They then show that a falling-edge line ignores the opposite transition. After that, a seeded random phase runs. It rewrites whole style words with codes that include the disabled values, toggles sparse pin sets and issues random clear masks. Every cycle, status and irq_o are compared with a cycle-accurate bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [2:0] STY_LVL_HI = 3'd0;
  localparam logic [2:0] STY_LVL_LO = 3'd1;
  localparam logic [2:0] STY_RISE   = 3'd2;
  localparam logic [2:0] STY_FALL   = 3'd3;
  localparam logic [2:0] STY_ANY    = 3'd4;

  // word index = byte address [4:2]
  localparam logic [2:0] W_OUT  = 3'd0;
  localparam logic [2:0] W_DIR  = 3'd1;
  localparam logic [2:0] W_IN   = 3'd2;
  localparam logic [2:0] W_STAT = 3'd3;
  localparam logic [2:0] W_TLO  = 3'd4;
  localparam logic [2:0] W_THI  = 3'd5;
  localparam logic [2:0] W_CLK  = 3'd6;
  localparam logic [2:0] W_DBS  = 3'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_irq_pkg::*;
#(
  parameter int STYLE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_i,
  input  logic [STYLE_W-1:0] style_i,
  output logic               hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  always_comb begin
    unique case (style_i)
      STY_LVL_HI: hit_o = smp_i;
      STY_LVL_LO: hit_o = ~smp_i;
      STY_RISE:   hit_o = smp_i & ~prev_q;
      STY_FALL:   hit_o = ~smp_i & prev_q;
      STY_ANY:    hit_o = smp_i ^ prev_q;
      default:    hit_o = 1'b0;  // codes 5..7 disabled
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES     = 16,
  parameter int NUM_IRQ       = 13,
  parameter int STYLE_W       = 3,
  parameter int LINES_PER_REG = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  localparam int TYPE_W   = LINES_PER_REG * STYLE_W;
  localparam int NUM_TREG = NUM_LINES / LINES_PER_REG;

  logic [NUM_LINES-1:0] out_q, dir_q, stat_q, smp, hit, clr;
  logic [TYPE_W-1:0]    type_q [NUM_TREG];
  logic [DATA_W-1:0]    clk_q, dbs_q;
  logic [2:0]           widx;
  logic                 aligned, wr_en;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_en   = req_i & we_i & aligned;

  gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    gpio_line_detect #(.STYLE_W(STYLE_W)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp[n]),
      .style_i(type_q[n / LINES_PER_REG][(n % LINES_PER_REG) * STYLE_W +: STYLE_W]),
      .hit_o  (hit[n])
    );
  end

  assign clr = (wr_en && widx == W_STAT) ? wdata_i[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '1;
      stat_q <= '0;
      clk_q  <= '0;
      dbs_q  <= '0;
      for (int r = 0; r < NUM_TREG; r++) type_q[r] <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;  // set wins over clear
      if (wr_en) begin
        case (widx)
          W_OUT:   out_q <= wdata_i[NUM_LINES-1:0];
          W_DIR:   dir_q <= wdata_i[NUM_LINES-1:0];
          W_CLK:   clk_q <= wdata_i;
          W_DBS:   dbs_q <= wdata_i;
          default: ;
        endcase
        for (int r = 0; r < NUM_TREG; r++)
          if (widx == 3'(int'(W_TLO) + r)) type_q[r] <= wdata_i[TYPE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (widx)
        W_OUT:   rdata_o = DATA_W'(out_q);
        W_DIR:   rdata_o = DATA_W'(dir_q);
        W_IN:    rdata_o = DATA_W'(smp);
        W_STAT:  rdata_o = DATA_W'(stat_q);
        W_CLK:   rdata_o = clk_q;
        W_DBS:   rdata_o = dbs_q;
        default: ;
      endcase
      for (int r = 0; r < NUM_TREG; r++)
        if (widx == 3'(int'(W_TLO) + r)) rdata_o = DATA_W'(type_q[r]);
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = stat_q[NUM_IRQ-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_IRQ   = 13,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] pin_o,
  input logic [NUM_LINES-1:0] pin_oe_o,
  input logic [NUM_IRQ-1:0]   irq_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  AST_IRQ_STATUS_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && addr_i[ADDR_W-1:2] == W_STAT) |-> (rdata_o[NUM_IRQ-1:0] == irq_o)); // R10

  AST_OE_DIR_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && addr_i[ADDR_W-1:2] == W_DIR) |-> (rdata_o[NUM_LINES-1:0] == ~pin_oe_o)); // R3

  AST_OUT_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && addr_i[ADDR_W-1:2] == W_OUT) |-> (rdata_o[NUM_LINES-1:0] == pin_o)); // R3

  AST_MISALIGNED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aligned) |-> (rdata_o == '0)); // R2

  AST_TYPE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && (addr_i[ADDR_W-1:2] == W_TLO || addr_i[ADDR_W-1:2] == W_THI))
      |-> (rdata_o[DATA_W-1:24] == '0)); // R2

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && aligned && addr_i[ADDR_W-1:2] == W_STAT)
      |=> ((irq_o & $past(irq_o)) == $past(irq_o))); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] pins = '0, pin_o, pin_oe_o;
  logic [12:0] irq_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic [15:0] m_s1, m_s2, m_prev, m_stat, m_clr, m_hit;
  logic [23:0] m_tlo, m_thi;

  function automatic logic [15:0] calc_hit(logic [15:0] s, logic [15:0] p,
                                           logic [23:0] tlo, logic [23:0] thi);
    logic [15:0] h;
    logic [2:0]  c;
    for (int i = 0; i < 16; i++) begin
      c = (i < 8) ? tlo[i*3 +: 3] : thi[(i-8)*3 +: 3];
      case (c)
        3'd0: h[i] = s[i];
        3'd1: h[i] = ~s[i];
        3'd2: h[i] = s[i] & ~p[i];
        3'd3: h[i] = ~s[i] & p[i];
        3'd4: h[i] = s[i] ^ p[i];
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  assign m_hit = calc_hit(m_s2, m_prev, m_tlo, m_thi);
  assign m_clr = (req && we && addr == 5'h0C) ? wdata[15:0] : 16'h0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0; m_tlo <= '0; m_thi <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      m_stat <= (m_stat & ~m_clr) | m_hit;
      if (req && we && addr == 5'h10) m_tlo <= wdata[23:0];
      if (req && we && addr == 5'h14) m_thi <= wdata[23:0];
    end
  end

  logic [23:0] sh_lo = '0, sh_hi = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk_i); @(negedge clk_i);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_style(int line, logic [2:0] code);
    if (line < 8) begin sh_lo[line*3 +: 3] = code; wr(5'h10, {8'h0, sh_lo}); end
    else begin sh_hi[(line-8)*3 +: 3] = code; wr(5'h14, {8'h0, sh_hi}); end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    rd(5'h00, d); chk("R1 out", d, 0);
    rd(5'h04, d); chk("R1 dir", d, 32'h0000FFFF);
    rd(5'h10, d); chk("R1 type lo", d, 0);
    rd(5'h14, d); chk("R1 type hi", d, 0);
    rd(5'h0C, d); chk("R1 status", d, 0);
    chk("R1 oe", pin_oe_o, 0);
    chk("R1 irq", irq_o, 0);

    // disable every line: code 5 everywhere
    for (int i = 0; i < 8; i++) begin sh_lo[i*3 +: 3] = 3'd5; sh_hi[i*3 +: 3] = 3'd5; end
    // R2 unused type bits read zero
    wr(5'h10, 32'hFFFFFFFF); rd(5'h10, d); chk("R2 type lo width", d, 32'h00FFFFFF);
    wr(5'h10, {8'h0, sh_lo}); wr(5'h14, {8'h0, sh_hi});
    rd(5'h14, d); chk("R2 type hi", d, {8'h0, sh_hi});
    wr(5'h18, 32'hDEADBEEF); rd(5'h18, d); chk("R2 clk word", d, 32'hDEADBEEF);
    wr(5'h1C, 32'h12345678); rd(5'h1C, d); chk("R2 dbs word", d, 32'h12345678);
    wr(5'h00, 32'hFFFF1234); rd(5'h00, d); chk("R2 out width", d, 32'h00001234);
    wr(5'h01, 32'h0000FFFF); rd(5'h00, d); chk("R2 misaligned write ignored", d, 32'h00001234);
    rd(5'h01, d); chk("R2 misaligned read zero", d, 0);

    // R3 direction and output drive
    wr(5'h04, 32'h0000F00F);
    chk("R3 oe", pin_oe_o, 16'h0FF0);
    chk("R3 pin_o", pin_o, 16'h1234);

    // R4 input sampling latency, independent of direction
    pins = 16'h3C5A;
    step(1); rd(5'h08, d); chk("R4 in after 1 edge", d, 0);
    step(1); rd(5'h08, d); chk("R4 in after 2 edges", d, 32'h00003C5A);
    pins = 16'h0000; step(3);
    rd(5'h0C, d); chk("R8 disabled lines no status", d, 0);

    // R11 / R7 rising latency on line 3
    set_style(3, 3'd2);
    pins[3] = 1;
    step(2); chk("R11 irq3 after 2 edges", irq_o[3], 0);
    step(1); chk("R11 irq3 after 3 edges", irq_o[3], 1);
    wr(5'h0C, 32'h8); chk("R9 clear line3", irq_o[3], 0);
    step(3); chk("R7 rising no re-set while high", irq_o[3], 0);

    // R6 active-low level on line 5 (pin low)
    set_style(5, 3'd1);
    step(1); chk("R6 low level sets", irq_o[5], 1);
    wr(5'h0C, 32'h20); chk("R6 clear under active level", irq_o[5], 1);
    pins[5] = 1; step(3);
    wr(5'h0C, 32'h20); chk("R6 clear after level gone", irq_o[5], 0);
    step(2); chk("R6 stays clear", irq_o[5], 0);

    // R7 falling on line 12, R9 zero-write
    set_style(12, 3'd3);
    pins[12] = 1; step(3); chk("R7 falling ignores rise", irq_o[12], 0);
    pins[12] = 0; step(3); chk("R7 falling sets", irq_o[12], 1);
    wr(5'h0C, 32'h0); chk("R9 write zero keeps", irq_o[12], 1);
    wr(5'h0C, 32'h0FFF); chk("R9 other bits keep", irq_o[12], 1);
    wr(5'h0C, 32'h1000); chk("R9 write one clears", irq_o[12], 0);

    // R5 upper word field 0, either edge on line 8
    set_style(8, 3'd4);
    pins[8] = 1; step(3); chk("R5 line8 any rise", irq_o[8], 1);
    wr(5'h0C, 32'h100);
    pins[8] = 0; step(3); chk("R7 line8 any fall", irq_o[8], 1);
    wr(5'h0C, 32'h100);

    // R8 code 6 on line 2
    set_style(2, 3'd6);
    pins[2] = 1; step(3); pins[2] = 0; step(3);
    rd(5'h0C, d); chk("R8 code6 no status", d[2], 0);

    // R5 / R10 line 15 top field: status only, no irq
    set_style(15, 3'd2);
    pins[15] = 1; step(3);
    rd(5'h0C, d); chk("R5 line15 status", d, 32'h00008000);
    chk("R10 no irq for line15", irq_o, 0);
    wr(5'h0C, 32'hFFFF);

    // random phase against the model (R6 R7 R8 R9 R10)
    for (int it = 0; it < 3000; it++) begin
      int r;
      pins = pins ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      r = int'($urandom % 8);
      if (r == 0)      begin req = 1; we = 1; addr = 5'h10; wdata = $urandom; end
      else if (r == 1) begin req = 1; we = 1; addr = 5'h14; wdata = $urandom; end
      else if (r == 2) begin req = 1; we = 1; addr = 5'h0C; wdata = $urandom; end
      @(posedge clk_i); @(negedge clk_i);
      req = 0; we = 0;
      rd(5'h0C, d);
      if (d[15:0] !== m_stat) chk("R9 random status", d, {16'h0, m_stat});
      else n_tests++;
      if (irq_o !== m_stat[12:0]) chk("R10 random irq", {19'h0, irq_o}, {19'h0, m_stat[12:0]});
      else n_tests++;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule